// File: doc/BRIEF.md
# Serial Frame Transmitter with Holding Register

This block turns parallel words into asynchronous serial frames on a single output line. Software-style logic hands it one word at a time through a write strobe. The word lands in a one-word holding register. When the line is free, the word moves into a shift register and goes out as a frame: a low start bit, the data bits least significant first, an optional parity bit, and a high stop bit. Because the holding register is separate from the shifter, the next word can be written while the current frame is still on the line. That word then follows the current stop bit with no idle gap.

Two flags report progress. `hold_empty` shows that the holding register can take a word. `tx_done` shows that the last frame has fully left the line. Bit timing comes from a two-stage divider: a prescaler counts `divisor` clock cycles, and an oversampling stage counts 16 or 8 of those. One bit therefore lasts `16*divisor` or `8*divisor` clock cycles. The divisor and the oversampling choice are captured only while the global enable is low. The transmitter runs only while both the global enable and the transmitter enable are high.

The controller has five states. IDLE holds the line high. START drives the start bit. DATA drives the shifter's low bit. PARITY drives the stored parity bit. STOP drives the stop bit. The transitions are:
- IDLE to START when a word is waiting and both enables are high. This is the take.
- START to DATA at the end of the bit.
- DATA to PARITY, or DATA to STOP when parity is off, after the last data bit.
- PARITY to STOP at the end of the bit.
- STOP to START when a word is waiting at the end of the stop bit. This is the back-to-back take.
- STOP to IDLE otherwise.
- Any state to IDLE whenever an enable is low. This is the abort.

Top module: `serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: Each bit lasts P clock cycles, where P = M * D. M is 16 when `os8_sel` is 0 and 8 when it is 1. D is the captured divisor, and a divisor of 0 counts as 1.
- R3: `divisor` and `os8_sel` are captured on each clock edge where `en_global` is 0. Changes made while `en_global` is 1 have no effect on timing.
- R4: A frame is a start bit of 0, then the data bits least significant bit first, then the parity bit if parity is enabled, then a stop bit of 1. Between frames the line is 1.
- R5: When `word9_sel` is 1, nine data bits `wr_data[8:0]` are sent. When it is 0, eight bits `wr_data[7:0]` are sent and `wr_data[8]` is ignored. The value is sampled when the word enters the shifter.
- R6: `par_sel` selects the parity. 2'b01 is even: the parity bit makes the count of ones over the data and parity bits even. 2'b10 is odd. 2'b00 and 2'b11 send no parity bit. The value is sampled when the word enters the shifter.
- R7: A write with `wr_valid`=1 while `hold_empty`=1 stores `wr_data` and clears `hold_empty` at the next edge. `hold_empty` returns to 1 on the edge where the word moves into the shifter, which is the same edge where the start bit begins.
- R8: A write while `hold_empty`=0 is ignored. The waiting word is neither replaced nor duplicated.
- R9: An accepted write clears `tx_done`. `tx_done` becomes 1 only on the edge that ends a stop bit when no word is waiting. Emptying the holding register never sets it.
- R10: A word waiting when a stop bit ends starts its start bit on that same edge, with no idle cycle.
- R11: No bit is sent unless `en_global` and `en_tx` are both 1. If either enable is 0 on an edge, the frame in progress is dropped and `txd` is 1 in the following cycle. A waiting word stays in the holding register until both enables return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_global | input | 1 | Global enable; the divisor and oversampling choice are captured while it is low |
| en_tx | input | 1 | Transmitter enable |
| os8_sel | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| divisor | input | DIV_W | Prescaler divisor |
| word9_sel | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_sel | input | 2 | Parity mode: 01 even, 10 odd, 00 or 11 none |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can take a word |
| tx_done | output | 1 | Last frame fully sent, including the stop bit |

## Verification
The hardest cases to reach are the ones where several events land on a single edge.

The first is the back-to-back take. A second word must already be waiting when the stop bit ends, and a third write must arrive while the register is full so that it is dropped. The stimulus gets there by writing three times in quick succession right after a take.

The second is an abort. An enable is dropped partway through a frame, and separately a write is made while the transmitter is disabled; both exercise the case where the holding register must keep its word.

The third is the rule that the divisor is frozen while enabled. It is reached by changing the divisor with the global enable high and then timing the next start bit.

A behavioural frame model in the bench follows every clock, so each of these cases is compared cycle by cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned WORD_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

    function automatic logic par_value(input logic [WORD_W-1:0] d,
                                       input logic [1:0] mode);
        return (^d) ^ (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
    parameter int unsigned DIV_W     = 12,
    parameter int unsigned DIV_RESET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_global,
    input  logic             os8_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             run,
    output logic             bit_tick
);

    localparam int unsigned SUB_W = 4;
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [DIV_W-1:0] div_q;
    logic             os8_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] pre_cnt;
    logic [SUB_W-1:0] sub_cnt;
    logic [SUB_W-1:0] sub_last;
    logic             pre_wrap;
    logic             sub_wrap;

    // configuration capture: only while the whole block is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RESET);
            os8_q <= 1'b0;
        end else if (!en_global) begin
            div_q <= divisor;
            os8_q <= os8_sel;
        end
    end

    assign div_eff  = (div_q == '0) ? DIV_ONE : div_q;
    assign sub_last = os8_q ? SUB_W'(7) : SUB_W'(15);
    assign pre_wrap = (pre_cnt == div_eff - DIV_ONE);
    assign sub_wrap = (sub_cnt == sub_last);
    assign bit_tick = run && pre_wrap && sub_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            sub_cnt <= sub_wrap ? '0 : sub_cnt + SUB_W'(1);
        end else begin
            pre_cnt <= pre_cnt + DIV_ONE;
        end
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic              wr_accept,
    output logic              hold_empty,
    output logic [WORD_W-1:0] hold_q
);

    assign wr_accept = wr_valid && hold_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_empty <= 1'b1;
            hold_q     <= '0;
        end else if (wr_accept) begin
            hold_empty <= 1'b0;
            hold_q     <= wr_data;
        end else if (take) begin
            hold_empty <= 1'b1;
        end
    end

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              hold_empty,
    input  logic [WORD_W-1:0] hold_q,
    input  logic              word9_sel,
    input  logic [1:0]        par_sel,
    input  logic              bit_tick,
    input  logic              wr_accept,
    output logic              take,
    output logic              run,
    output logic              txd,
    output logic              tx_done
);

    localparam int unsigned CNT_W = 4;

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [CNT_W-1:0]  last_q;
    logic              par_en_q;
    logic              par_q;
    logic              waiting;
    logic              last_data;
    logic              stop_end;
    logic [WORD_W-1:0] masked;

    assign waiting   = enabled && !hold_empty;
    assign last_data = (bitcnt_q == last_q);
    assign stop_end  = (state_q == ST_STOP) && bit_tick;
    assign take      = waiting && ((state_q == ST_IDLE) || stop_end);
    assign run       = (state_q != ST_IDLE);
    assign masked    = word9_sel ? hold_q : {1'b0, hold_q[WORD_W-2:0]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (waiting)  state_d = ST_START;
            ST_START:  if (bit_tick) state_d = ST_DATA;
            ST_DATA:   if (bit_tick && last_data)
                           state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_tick) state_d = ST_STOP;
            ST_STOP:   if (bit_tick) state_d = waiting ? ST_START : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!enabled) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            last_q   <= CNT_W'(7);
            par_en_q <= 1'b0;
            par_q    <= 1'b0;
        end else if (take) begin
            shreg_q  <= masked;
            bitcnt_q <= '0;
            last_q   <= word9_sel ? CNT_W'(8) : CNT_W'(7);
            par_en_q <= par_on(par_sel);
            par_q    <= par_value(masked, par_sel);
        end else if ((state_q == ST_DATA) && bit_tick) begin
            shreg_q  <= shreg_q >> 1;
            bitcnt_q <= bitcnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          tx_done <= 1'b1;
        else if (wr_accept)                  tx_done <= 1'b0;
        else if (stop_end && enabled && !take) tx_done <= 1'b1;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = par_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
    parameter int unsigned DIV_W     = 12,
    parameter int unsigned DIV_RESET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_global,
    input  logic             en_tx,
    input  logic             os8_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             word9_sel,
    input  logic [1:0]       par_sel,
    input  logic             wr_valid,
    input  logic [8:0]       wr_data,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_done
);

    logic       enabled;
    logic       take;
    logic       run;
    logic       bit_tick;
    logic       wr_accept;
    logic [8:0] hold_q;

    assign enabled = en_global && en_tx;

    sertx_tick #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_global (en_global),
        .os8_sel   (os8_sel),
        .divisor   (divisor),
        .run       (run),
        .bit_tick  (bit_tick)
    );

    sertx_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .take       (take),
        .wr_accept  (wr_accept),
        .hold_empty (hold_empty),
        .hold_q     (hold_q)
    );

    sertx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enabled    (enabled),
        .hold_empty (hold_empty),
        .hold_q     (hold_q),
        .word9_sel  (word9_sel),
        .par_sel    (par_sel),
        .bit_tick   (bit_tick),
        .wr_accept  (wr_accept),
        .take       (take),
        .run        (run),
        .txd        (txd),
        .tx_done    (tx_done)
    );

endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk #(
    parameter int unsigned DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_global,
    input logic             en_tx,
    input logic             wr_valid,
    input logic             txd,
    input logic             hold_empty,
    input logic             tx_done,
    input logic [DIV_W-1:0] div_q,
    input logic [8:0]       hold_q
);

    assert_abort_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_global && en_tx) |=> txd);

    assert_hold_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en_global && en_tx) && !hold_empty) |=> !hold_empty);

    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && hold_empty) |=> (!hold_empty && !tx_done));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (txd && hold_empty));

    assert_full_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !hold_empty) |=> $stable(hold_q));

    assert_div_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_global |=> $stable(div_q));

    assert_take_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !txd);

endmodule

bind serial_tx serial_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_global  (en_global),
    .en_tx      (en_tx),
    .wr_valid   (wr_valid),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .div_q      (u_tick.div_q),
    .hold_q     (u_hold.hold_q)
);

// File: tb/serial_tx_bench.sv
`timescale 1ns/1ps
module serial_tx_bench;

    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_global = 1'b0;
    logic             en_tx = 1'b0;
    logic             os8_sel = 1'b0;
    logic [DIV_W-1:0] divisor = 12'd1;
    logic             word9_sel = 1'b0;
    logic [1:0]       par_sel = 2'b00;
    logic             wr_valid = 1'b0;
    logic [8:0]       wr_data = '0;
    logic             txd;
    logic             hold_empty;
    logic             tx_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R4";

    always #10 clk = ~clk;

    serial_tx #(.DIV_W(DIV_W)) u_serial_tx (
        .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_tx(en_tx),
        .os8_sel(os8_sel), .divisor(divisor), .word9_sel(word9_sel),
        .par_sel(par_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
    );

    // behavioural reference model
    bit   mq[$];
    int   m_cnt;
    bit   m_busy;
    bit   m_full;
    bit [8:0] m_hold;
    bit   m_done;
    bit   m_txd;
    int   m_div;
    bit   m_os8;

    task automatic build_frame(input bit [8:0] d, input bit w9, input bit [1:0] pm);
        int n;
        int ones;
        n = w9 ? 9 : 8;
        ones = 0;
        mq.delete();
        mq.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            mq.push_back(d[i]);
            if (d[i]) ones++;
        end
        if (pm == 2'b01) mq.push_back(ones % 2 == 1);
        if (pm == 2'b10) mq.push_back(ones % 2 == 0);
        mq.push_back(1'b1);
        m_busy = 1; m_cnt = 0; m_full = 0; m_txd = mq[0];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_cnt = 0; m_busy = 0; m_full = 0; m_hold = 0;
            m_done = 1; m_txd = 1; m_div = 1; m_os8 = 0;
        end else begin
            bit en;
            bit wr_ok;
            bit full_old;
            int p;
            en = en_global && en_tx;
            wr_ok = wr_valid && !m_full;
            full_old = m_full;
            p = (m_os8 ? 8 : 16) * (m_div == 0 ? 1 : m_div);
            if (!en) begin
                m_busy = 0; mq.delete(); m_txd = 1;
            end else if (m_busy) begin
                m_cnt++;
                if (m_cnt == p) begin
                    m_cnt = 0;
                    void'(mq.pop_front());
                    if (mq.size() == 0) begin
                        if (full_old) build_frame(m_hold, word9_sel, par_sel);
                        else begin m_busy = 0; m_txd = 1; m_done = 1; end
                    end else m_txd = mq[0];
                end
            end else if (full_old) begin
                build_frame(m_hold, word9_sel, par_sel);
            end
            if (wr_ok) begin m_hold = wr_data; m_full = 1; m_done = 0; end
            if (!en_global) begin m_div = int'(divisor); m_os8 = os8_sel; end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(txd == m_txd, cur_req, "txd", int'(txd), int'(m_txd));
            check(hold_empty == !m_full, "R7", "hold_empty", int'(hold_empty), int'(!m_full));
            check(tx_done == m_done, "R9", "tx_done", int'(tx_done), int'(m_done));
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input bit [8:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic reconfig(input int dv, input bit o8);
        @(negedge clk); en_global = 1'b0; divisor = DIV_W'(dv); os8_sel = o8;
        @(negedge clk); en_global = 1'b1;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!m_busy && !m_full) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic time_start(input string req, input bit [8:0] d, input int exp);
        int n;
        n = 0;
        send(d);
        for (int i = 0; i < 100 && txd; i++) @(negedge clk);
        while (!txd && n < 1000) begin n++; @(negedge clk); end
        check(n == exp, req, "start bit length", n, exp);
        wait_quiet();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
        check(hold_empty == 1'b1, "R1", "reset hold_empty", int'(hold_empty), 1);
        check(tx_done == 1'b1, "R1", "reset tx_done", int'(tx_done), 1);
        en_global = 1'b1; en_tx = 1'b1;

        cur_req = "R4";
        send(9'h0A5); wait_quiet();
        send(9'h03C); wait_quiet();

        cur_req = "R2";
        time_start("R2", 9'h001, 16);
        reconfig(2, 1'b1);
        time_start("R2", 9'h0FF, 16);
        reconfig(0, 1'b1);
        time_start("R2", 9'h055, 8);
        reconfig(3, 1'b0);
        time_start("R2", 9'h001, 48);

        cur_req = "R3";
        reconfig(1, 1'b1);
        @(negedge clk); divisor = 12'd5; os8_sel = 1'b0;
        time_start("R3", 9'h081, 8);

        cur_req = "R5";
        word9_sel = 1'b1; send(9'h1A3); wait_quiet();
        word9_sel = 1'b0; send(9'h1A3); wait_quiet();

        cur_req = "R6";
        par_sel = 2'b01; send(9'h007); wait_quiet();
        par_sel = 2'b10; send(9'h007); wait_quiet();
        par_sel = 2'b11; send(9'h0F0); wait_quiet();
        word9_sel = 1'b1; par_sel = 2'b10; send(9'h100); wait_quiet();
        word9_sel = 1'b0; par_sel = 2'b00;

        cur_req = "R10";
        send(9'h0C3);
        send(9'h05A);
        cur_req = "R8";
        send(9'h0FF);
        check(hold_empty == 1'b0, "R8", "hold full after ignored write", int'(hold_empty), 0);
        wait_quiet();

        cur_req = "R11";
        en_tx = 1'b0;
        send(9'h099);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!txd) begin
                check(1'b0, "R11", "line low while disabled", 0, 1);
                break;
            end
        end
        check(hold_empty == 1'b0, "R11", "word kept while disabled", int'(hold_empty), 0);
        en_tx = 1'b1; wait_quiet();
        send(9'h0E7);
        repeat (40) @(negedge clk);
        en_tx = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(txd == 1'b1, "R11", "line high after abort", int'(txd), 1);
        en_tx = 1'b1;
        cur_req = "R9";
        send(9'h011); wait_quiet();
        check(tx_done == 1'b1, "R9", "done after last frame", int'(tx_done), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule